// File: doc/BRIEF.md
# Three-Level Address Translation Walker

This block turns a 32-bit linear address into a 36-bit physical address by reading three levels of translation tables from memory. Each table entry is 64 bits (8 bytes). The top table has only four entries and is indexed by the two most significant address bits. Its base comes from a root input. The next two tables have 512 entries each and are indexed by 9-bit fields. The final entry names a 4-KB frame, and the low 12 address bits pass through unchanged as the page offset.

A client presents the linear address with a one-cycle request pulse while the walker is idle. The walker then issues up to three reads on a 64-bit memory port. Each read holds its request and address until the memory acknowledges and returns data in that same cycle. The walker ends with a one-cycle done pulse that carries either the physical address or a fault.

Top module: `addr_walk3`

## Requirements
- R1: While reset is asserted and after it is released with no request, `done_o`, `fault_o`, `mem_req_o` and `phys_addr_o` are all zero.
- R2: The first read is issued in the cycle after the request is taken. Its address is `{root_i[35:5], lin_addr_i[31:30], 3'b000}`, and the low five bits of `root_i` are ignored.
- R3: The second read address is `{e1[35:12], lin[29:21], 3'b000}`, where `e1` is the data returned by the first read.
- R4: The third read address is `{e2[35:12], lin[20:12], 3'b000}`, where `e2` is the data returned by the second read.
- R5: After a successful third read, the done pulse carries `phys_addr_o = {e3[35:12], lin[11:0]}` with `fault_o = 0`.
- R6: Bit 0 of an entry is its present flag. A returned entry with bit 0 clear, at any level, ends the walk: no further read is issued, and the done pulse has `fault_o = 1` and `phys_addr_o = 0`.
- R7: While a read is not acknowledged, `mem_req_o` stays high and `mem_addr_o` does not change.
- R8: `done_o` rises in the cycle after the acknowledge that ends the walk and lasts exactly one cycle. The walker then returns to idle.
- R9: A request that arrives while a walk is in progress is ignored, and the walk in progress continues unchanged.
- R10: Entry bits 63:36 and 11:1 have no effect on any read address or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Translation request pulse, taken only when idle |
| lin_addr_i | input | 32 | Linear address to translate |
| root_i | input | 36 | Base of the four-entry top table |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 36 | Byte address of the entry being read |
| mem_ack_i | input | 1 | Memory acknowledge; data is valid in the same cycle |
| mem_rdata_i | input | 64 | Entry data returned by memory |
| done_o | output | 1 | One-cycle completion strobe |
| fault_o | output | 1 | Walk ended on a non-present entry; valid with done_o |
| phys_addr_o | output | 36 | Translated physical address; valid with done_o |

## Verification
The first read address is due one cycle after the request edge. Each later read address is due one cycle after the edge that consumed the previous acknowledge. The done pulse is due exactly one cycle after the final acknowledge. The bench keeps this timing by playing the memory itself on the falling edge: it waits a random 0 to 2 cycles before each acknowledge and counts the falling edges since that acknowledge. It then requires the read address, or `done_o` with its result, at exactly the expected edge, and checks that the address stays stable during every wait.

// File: rtl/walk_pkg.sv
package walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_L1   = 3'd1,
    ST_L2   = 3'd2,
    ST_L3   = 3'd3,
    ST_DONE = 3'd4
  } walk_st_e;
endpackage

// File: rtl/walk_idx_gen.sv
module walk_idx_gen
  import walk_pkg::*;
#(
  parameter int LA_W    = 32,
  parameter int PA_W    = 36,
  parameter int OFF_W   = 12,
  parameter int TOP_W   = 2,
  parameter int MID_W   = 9,
  parameter int ESZ_LOG = 3
) (
  input  walk_st_e          st_i,
  input  logic [PA_W-1:0]   root_i,
  input  logic [PA_W-1:0]   base_i,
  input  logic [LA_W-1:0]   la_i,
  output logic [PA_W-1:0]   addr_o
);
  localparam int TOP_LSB  = LA_W - TOP_W;
  localparam int MID_LVLS = 2;
  localparam int ROOT_LSB = TOP_W + ESZ_LOG;

  logic [MID_W-1:0] mid_idx [MID_LVLS];

  for (genvar g = 0; g < MID_LVLS; g++) begin : g_mid
    assign mid_idx[g] = la_i[TOP_LSB-1-g*MID_W -: MID_W];
  end

  logic unused_idx;
  assign unused_idx = ^{root_i[ROOT_LSB-1:0], base_i[OFF_W-1:0], la_i[OFF_W-1:0]};

  always_comb begin
    unique case (st_i)
      ST_L1:   addr_o = {root_i[PA_W-1:ROOT_LSB], la_i[LA_W-1:TOP_LSB], {ESZ_LOG{1'b0}}};
      ST_L2:   addr_o = {base_i[PA_W-1:OFF_W], mid_idx[0], {ESZ_LOG{1'b0}}};
      ST_L3:   addr_o = {base_i[PA_W-1:OFF_W], mid_idx[1], {ESZ_LOG{1'b0}}};
      default: addr_o = '0;
    endcase
  end
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_i,
  input  logic     ack_i,
  input  logic     present_i,
  output walk_st_e st_o,
  output logic     fault_o
);
  walk_st_e st_q, st_d;
  logic     fault_q;
  logic     reading;

  assign reading = (st_q == ST_L1) || (st_q == ST_L2) || (st_q == ST_L3);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_i) st_d = ST_L1;
      ST_L1:   if (ack_i) st_d = present_i ? ST_L2 : ST_DONE;
      ST_L2:   if (ack_i) st_d = present_i ? ST_L3 : ST_DONE;
      ST_L3:   if (ack_i) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_i) fault_q <= 1'b0;
      else if (reading && ack_i && !present_i) fault_q <= 1'b1;
    end
  end

  assign st_o    = st_q;
  assign fault_o = fault_q;

  // R9
  l1_only_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> (st_q != ST_L1) || ($past(st_q) == ST_L1));
  // R8
  done_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DONE) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/addr_walk3.sv
module addr_walk3
  import walk_pkg::*;
#(
  parameter int LA_W    = 32,
  parameter int PA_W    = 36,
  parameter int ENT_W   = 64,
  parameter int OFF_W   = 12,
  parameter int TOP_W   = 2,
  parameter int MID_W   = 9,
  parameter int ESZ_LOG = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [LA_W-1:0]   lin_addr_i,
  input  logic [PA_W-1:0]   root_i,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [ENT_W-1:0]  mem_rdata_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [PA_W-1:0]   phys_addr_o
);
  localparam int FRM_W = PA_W - OFF_W;

  walk_st_e         st;
  logic             fault;
  logic             present;
  logic [LA_W-1:0]  la_q;
  logic [PA_W-1:0]  base_q;
  logic [PA_W-1:0]  phys_q;
  logic [FRM_W-1:0] frame;

  assign present = mem_rdata_i[0];
  assign frame   = mem_rdata_i[PA_W-1:OFF_W];

  logic unused_rdata;
  assign unused_rdata = ^{mem_rdata_i[ENT_W-1:PA_W], mem_rdata_i[OFF_W-1:1]};

  walk_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .ack_i     (mem_ack_i),
    .present_i (present),
    .st_o      (st),
    .fault_o   (fault)
  );

  walk_idx_gen #(
    .LA_W(LA_W), .PA_W(PA_W), .OFF_W(OFF_W),
    .TOP_W(TOP_W), .MID_W(MID_W), .ESZ_LOG(ESZ_LOG)
  ) u_idx (
    .st_i   (st),
    .root_i (root_i),
    .base_i (base_q),
    .la_i   (la_q),
    .addr_o (mem_addr_o)
  );

  assign mem_req_o = (st == ST_L1) || (st == ST_L2) || (st == ST_L3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      la_q   <= '0;
      base_q <= '0;
      phys_q <= '0;
    end else begin
      if (st == ST_IDLE && req_i) begin
        la_q   <= lin_addr_i;
        phys_q <= '0;
      end
      if (mem_req_o && mem_ack_i) begin
        base_q <= {frame, {OFF_W{1'b0}}};
        if (st == ST_L3 && present) phys_q <= {frame, la_q[OFF_W-1:0]};
      end
    end
  end

  assign done_o      = (st == ST_DONE);
  assign fault_o     = done_o && fault;
  assign phys_addr_o = (done_o && !fault) ? phys_q : '0;

  // R7
  hold_until_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  fault_zero_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (done_o && phys_addr_o == '0));
  // R8
  done_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);
  // R6
  fault_after_absent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && !present) |=> (done_o && fault_o));
endmodule

// File: tb/addr_walk3_test.sv
`timescale 1ns/1ps
module addr_walk3_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] la = '0;
  logic [35:0] root = '0;
  logic        ack = 1'b0;
  logic [63:0] rdata = '0;
  logic        mem_req, done, fault;
  logic [35:0] mem_addr, phys;

  int checks = 0;
  int fails = 0;
  int fault_thr = 0;
  bit junk = 1'b0;
  logic [31:0] salt = 32'h1234_5678;

  always #2.5 clk = ~clk;

  addr_walk3 uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .lin_addr_i(la), .root_i(root),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(ack), .mem_rdata_i(rdata),
    .done_o(done), .fault_o(fault), .phys_addr_o(phys)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] entry(input logic [35:0] a);
    logic [31:0] h, g;
    logic [63:0] e;
    h = (a[31:0] ^ {a[35:32], 28'h0} ^ salt) * 32'h9E37_79B1;
    g = (h ^ (h >> 15)) * 32'h85EB_CA6B;
    g = g ^ (g >> 13);
    e = {h[27:0], g[31:8], h[11:1], (g[3:0] >= 4'(fault_thr))};
    if (junk) begin
      e[63:36] = '1;
      e[11:1]  = '1;
    end
    return e;
  endfunction

  task automatic walk(input logic [31:0] a, input logic [35:0] r, input int absent_lvl, input bit poke);
    logic [35:0] exp_addr, exp_phys;
    logic [63:0] d;
    bit exp_fault = 1'b0, stop = 1'b0, ended = 1'b0;
    int lvl = 0, wt, cyc = 0, since_ack = 99;
    string tag;
    @(negedge clk);
    la = a; root = r; req = 1'b1;
    exp_addr = {r[35:5], a[31:30], 3'b000};
    exp_phys = '0;
    wt = $urandom % 3;
    while (!ended) begin
      @(negedge clk);
      cyc++; since_ack++;
      req = 1'b0; ack = 1'b0; rdata = {$urandom, $urandom};
      if (cyc == 1) chk(mem_req === 1'b1, "R2 read due after request", 64'(mem_req), 64'd1);
      if (poke && cyc == 2) begin req = 1'b1; la = ~a; end  // R9 late request
      if (done) begin
        tag = junk ? "R10 result" : (exp_fault ? "R6 result" : "R5 result");
        chk(since_ack == 1, "R8 done timing", 64'(since_ack), 64'd1);
        chk(fault === exp_fault, tag, 64'(fault), 64'(exp_fault));
        chk(phys === exp_phys, tag, 64'(phys), 64'(exp_phys));
        @(negedge clk);
        req = 1'b0;
        chk(done === 1'b0, "R8 done one cycle", 64'(done), 64'd0);
        chk(mem_req === 1'b0, "R8 idle after done", 64'(mem_req), 64'd0);
        ended = 1'b1;
      end else if (mem_req) begin
        if (stop) begin
          chk(1'b0, "R6 no read after end", 64'(mem_req), 64'd0);
          ended = 1'b1;
        end else if (wt == 0) begin
          tag = junk ? "R10 read addr" : (lvl == 0 ? "R2 read addr" : (lvl == 1 ? "R3 read addr" : "R4 read addr"));
          chk(mem_addr === exp_addr, tag, 64'(mem_addr), 64'(exp_addr));
          d = entry(exp_addr);
          if (lvl == absent_lvl) d[0] = 1'b0;
          ack = 1'b1; rdata = d; since_ack = 0;
          if (!d[0]) begin
            exp_fault = 1'b1; stop = 1'b1;
          end else if (lvl == 0) exp_addr = {d[35:12], a[29:21], 3'b000};
          else if (lvl == 1) exp_addr = {d[35:12], a[20:12], 3'b000};
          else begin
            exp_phys = {d[35:12], a[11:0]}; stop = 1'b1;
          end
          lvl++;
          wt = $urandom % 3;
        end else begin
          chk(mem_addr === exp_addr, "R7 address held", 64'(mem_addr), 64'(exp_addr));
          wt--;
        end
      end else begin
        chk(1'b0, stop ? "R8 done missing" : "R7 request dropped", 64'(mem_req), 64'd1);
        ended = 1'b1;
      end
      if (cyc > 60) begin
        chk(1'b0, "R8 walk timeout", 64'(cyc), 64'd60);
        ended = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk({done, fault, mem_req, phys} === '0, "R1 reset outputs", 64'({done, fault, mem_req, phys}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 idle after reset
    chk({done, fault, mem_req, phys} === '0, "R1 idle outputs", 64'({done, fault, mem_req, phys}), 64'd0);

    walk(32'h0000_0000, 36'h0_0000_0000, -1, 1'b0);
    walk(32'hFFFF_FFFF, 36'hF_FFFF_FFFF, -1, 1'b0);
    walk(32'h8020_1ABC, 36'h1_2345_671F, 0, 1'b0);   // R6 at level 1
    walk(32'h4030_2DEF, 36'h2_0000_0000, 1, 1'b0);   // R6 at level 2
    walk(32'hC1FF_F123, 36'h3_ABCD_E000, 2, 1'b0);   // R6 at level 3
    walk(32'h7654_3210, 36'h0_1000_0000, -1, 1'b1);  // R9
    walk(32'h3456_7890, 36'h0_2000_0000, 1, 1'b1);   // R9 with fault
    junk = 1'b1;                                     // R10
    for (int i = 0; i < 8; i++) walk($urandom, {$urandom, 4'(i)}, -1, 1'b0);
    junk = 1'b0;

    for (int i = 0; i < 200; i++) walk($urandom, {4'($urandom), $urandom}, -1, (i % 7) == 0);
    fault_thr = 3;
    for (int i = 0; i < 200; i++) walk($urandom, {4'($urandom), $urandom}, -1, (i % 5) == 0);

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule